// File: doc/BRIEF.md
# Synchronous Receive Character Error Checker

This block sits behind a byte-synchronous serial receiver. A deserializer hands it 8-bit characters, each made of 7 data bits and 1 parity bit, over a valid/ready stream. The block checks the parity of every accepted character against a programmable odd or even rule. On a mismatch it closes the current receive buffer, raises a parity status flag and an interrupt pulse that can be masked, increments a wrapping 16-bit error counter, and sends the receiver back to hunt mode.

While it hunts, the block drops characters. It leaves hunt mode when the receiver reports a sync match. In external-sync mode it leaves hunt mode on an external start-of-data marker instead, and carrier-detect gating is then switched off. A CRC-error status output follows an externally computed CRC verdict, delayed by one character.

The character stream never applies back-pressure: `in_ready` is held high. A character moves on every cycle in which `in_valid` is high. Characters that arrive while the channel is disabled, while the block is hunting, or (in normal mode) without carrier are consumed and have no effect.

Top module: `sync_rx_char_checker`

## Requirements
- R1: With `mode_even`=0 (odd, the reset choice), an accepted character is in error when its 8 bits hold an even number of ones.
- R2: With `mode_even`=1, an accepted character is in error when its 8 bits hold an odd number of ones.
- R3: While `mode_blkchk`=1, no parity error is ever flagged.
- R4: One cycle after the clock edge that accepts an erroneous character, `buf_close` and `hunt_req` pulse high for exactly one cycle, `hunting` becomes 1, and `stat_parity_err` becomes 1. `stat_parity_err` stays 1 until hunt mode is left.
- R5: `irq` pulses in the same cycle as `buf_close`, only if `irq_en` was high when the character was accepted, and lasts one cycle.
- R6: `err_count` increments by one per parity error and wraps from 16'hFFFF to 16'h0000.
- R7: A `cnt_load` while `chan_en`=0 sets `err_count` to `cnt_load_val` on the next cycle. A load while `chan_en`=1 is ignored.
- R8: While `hunting`=1, characters are ignored. Hunting ends after a cycle in which `sync_found` is high (`mode_extsync`=0) or `ext_sync` is high (`mode_extsync`=1). The other sync input has no effect.
- R9: With `mode_extsync`=0, a character is accepted only while `carrier_det`=1. With `mode_extsync`=1, `carrier_det` is ignored.
- R10: On each accepted character, `stat_crc_err` takes the `in_crc_bad` value that came with the previous accepted character.
- R11: After reset, `hunting`=1, `err_count`=0, and `buf_close`, `hunt_req`, `irq`, `stat_parity_err` and `stat_crc_err` are all 0.
- R12: `in_ready` is always 1. Characters presented while `chan_en`=0 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| chan_en | input | 1 | Channel enable |
| mode_even | input | 1 | 1 = even parity, 0 = odd parity |
| mode_blkchk | input | 1 | 1 = parity checking off |
| mode_extsync | input | 1 | 1 = external sync mode |
| in_valid | input | 1 | Character valid |
| in_ready | output | 1 | Always 1 |
| in_char | input | 8 | Received character, parity in bit 7 |
| in_crc_bad | input | 1 | CRC verdict that accompanies the character |
| carrier_det | input | 1 | Carrier present (normal mode only) |
| sync_found | input | 1 | Receiver sync match |
| ext_sync | input | 1 | External start-of-data marker |
| irq_en | input | 1 | Interrupt enable |
| cnt_load | input | 1 | Load request for the error counter |
| cnt_load_val | input | 16 | Value to load |
| err_count | output | 16 | Parity error counter |
| hunting | output | 1 | Hunt mode active |
| hunt_req | output | 1 | One-cycle return-to-hunt command |
| buf_close | output | 1 | One-cycle buffer close |
| irq | output | 1 | One-cycle receive interrupt |
| stat_parity_err | output | 1 | Parity error status flag |
| stat_crc_err | output | 1 | Delayed CRC error status flag |

## Verification
The assertions check, on every cycle, the properties that can be stated locally:
- every error ends in hunt mode;
- the counter is stable under an enabled channel unless it is counting;
- the counter steps by exactly one on an error;
- interrupts are single-cycle and follow the enable;
- no buffer close follows a character accepted with checking off.

The bench's scenarios are needed for the parity rules themselves, the choice between the two sync sources, carrier gating, the one-character CRC lag and the counter wrap. These depend on data values and on sequences that span several characters.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  localparam int DATA_W = 7;
  localparam int CHAR_W = DATA_W + 1;
  localparam int CNT_W  = 16;

  typedef struct packed {
    logic even;
    logic blkchk;
    logic extsync;
  } rx_mode_t;
endpackage

// File: rtl/rx_parity_eval.sv
module rx_parity_eval
  import sync_rx_pkg::*;
#(
  parameter int CW = CHAR_W
) (
  input  logic [CW-1:0] char_i,
  input  rx_mode_t      mode_i,
  input  logic          accept_i,
  output logic          err_o
);
  logic ones_odd;
  always_comb begin
    ones_odd = ^char_i;
    // odd rule fails on an even count, even rule fails on an odd count
    err_o = accept_i && !mode_i.blkchk && (ones_odd == mode_i.even);
  end
endmodule

// File: rtl/rx_err_counter.sv
module rx_err_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         chan_en,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_o <= '0;
    else if (inc_i)             cnt_o <= cnt_o + 1'b1;
    else if (load_i && !chan_en) cnt_o <= load_val_i;
  end

  a_r6_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    inc_i |=> cnt_o == $past(cnt_o) + 1'b1);
  a_r7_hold_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    (chan_en && !inc_i) |=> $stable(cnt_o));
endmodule

// File: rtl/rx_hunt_ctrl.sv
module rx_hunt_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic extsync_mode,
  input  logic sync_found,
  input  logic ext_sync,
  input  logic err_i,
  output logic hunting_o,
  output logic exit_o
);
  logic sel_sync;
  always_comb begin
    sel_sync = extsync_mode ? ext_sync : sync_found;
    exit_o   = hunting_o && sel_sync;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hunting_o <= 1'b1;
    else if (err_i)  hunting_o <= 1'b1;
    else if (exit_o) hunting_o <= 1'b0;
  end

  a_r4_err_to_hunt: assert property (@(posedge clk) disable iff (!rst_n)
    err_i |=> hunting_o);
  a_r8_leave_on_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (hunting_o && !sel_sync) |=> hunting_o);
endmodule

// File: rtl/rx_crc_lag.sv
module rx_crc_lag #(
  parameter int DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step_i,
  input  logic crc_bad_i,
  output logic flag_o
);
  logic [DEPTH-1:0] pipe;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pipe <= '0;
    else if (step_i) pipe <= {pipe[DEPTH-2:0], crc_bad_i};
  end
  assign flag_o = pipe[DEPTH-1];

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step_i |=> $stable(flag_o));
endmodule

// File: rtl/sync_rx_char_checker.sv
module sync_rx_char_checker
  import sync_rx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              chan_en,
  input  logic              mode_even,
  input  logic              mode_blkchk,
  input  logic              mode_extsync,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [CHAR_W-1:0] in_char,
  input  logic              in_crc_bad,
  input  logic              carrier_det,
  input  logic              sync_found,
  input  logic              ext_sync,
  input  logic              irq_en,
  input  logic              cnt_load,
  input  logic [CNT_W-1:0]  cnt_load_val,
  output logic [CNT_W-1:0]  err_count,
  output logic              hunting,
  output logic              hunt_req,
  output logic              buf_close,
  output logic              irq,
  output logic              stat_parity_err,
  output logic              stat_crc_err
);
  rx_mode_t mode;
  logic     accept, par_err, hunt_exit, carrier_ok;

  always_comb begin
    mode       = '{even: mode_even, blkchk: mode_blkchk, extsync: mode_extsync};
    carrier_ok = mode_extsync || carrier_det;
    accept     = in_valid && chan_en && !hunting && carrier_ok;
  end
  assign in_ready = 1'b1;

  rx_parity_eval #(.CW(CHAR_W)) u_par (
    .char_i(in_char), .mode_i(mode), .accept_i(accept), .err_o(par_err));

  rx_err_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .inc_i(par_err),
    .load_i(cnt_load), .load_val_i(cnt_load_val), .cnt_o(err_count));

  rx_hunt_ctrl u_hunt (
    .clk(clk), .rst_n(rst_n), .extsync_mode(mode_extsync),
    .sync_found(sync_found), .ext_sync(ext_sync), .err_i(par_err),
    .hunting_o(hunting), .exit_o(hunt_exit));

  rx_crc_lag #(.DEPTH(2)) u_crc (
    .clk(clk), .rst_n(rst_n), .step_i(accept), .crc_bad_i(in_crc_bad),
    .flag_o(stat_crc_err));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      buf_close       <= 1'b0;
      hunt_req        <= 1'b0;
      irq             <= 1'b0;
      stat_parity_err <= 1'b0;
    end else begin
      buf_close <= par_err;
      hunt_req  <= par_err;
      irq       <= par_err && irq_en;
      if (par_err)        stat_parity_err <= 1'b1;
      else if (hunt_exit) stat_parity_err <= 1'b0;
    end
  end

  a_r5_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
    irq |=> !irq);
  a_r5_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    par_err && !irq_en |=> !irq);
  a_r3_no_close_blk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && mode_blkchk) |=> !buf_close);
  a_r4_flag_with_close: assert property (@(posedge clk) disable iff (!rst_n)
    buf_close |-> stat_parity_err && hunting);
endmodule

// File: tb/sync_rx_char_checker_bench.sv
module sync_rx_char_checker_bench;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, chan_en, mode_even, mode_blkchk, mode_extsync;
  logic in_valid, in_ready, in_crc_bad, carrier_det, sync_found, ext_sync;
  logic irq_en, cnt_load;
  logic [7:0] in_char;
  logic [15:0] cnt_load_val, err_count;
  logic hunting, hunt_req, buf_close, irq, stat_parity_err, stat_crc_err;

  sync_rx_char_checker u_sync_rx_char_checker (.*);

  int total = 0, bad = 0;
  logic [15:0] e_cnt;
  logic e_hunt, e_par, e_stage, e_crc, e_close, e_irq;

  task automatic chk(string req, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic bad_parity(logic [7:0] c, logic even);
    int ones = 0;
    for (int i = 0; i < 8; i++) ones += c[i];
    return even ? (ones % 2 == 1) : (ones % 2 == 0);
  endfunction

  // one cycle: drive inputs at negedge, update model, compare at next negedge
  task automatic step(logic v, logic [7:0] c, logic crc, logic sf, logic xs,
                      logic ld, logic [15:0] lv);
    logic acc, err, sel;
    in_valid = v; in_char = c; in_crc_bad = crc; sync_found = sf;
    ext_sync = xs; cnt_load = ld; cnt_load_val = lv;
    acc = v && chan_en && !e_hunt && (mode_extsync || carrier_det);
    err = acc && !mode_blkchk && bad_parity(c, mode_even);
    sel = mode_extsync ? xs : sf;
    e_close = err;
    e_irq = err && irq_en;
    if (err) e_cnt = e_cnt + 16'd1;
    else if (ld && !chan_en) e_cnt = lv;
    if (err) begin e_par = 1'b1; e_hunt = 1'b1; end
    else if (e_hunt && sel) begin e_par = 1'b0; e_hunt = 1'b0; end
    if (acc) begin e_crc = e_stage; e_stage = crc; end
    @(negedge clk);
    in_valid = 1'b0; sync_found = 1'b0; ext_sync = 1'b0; cnt_load = 1'b0;
    chk("R4", "buf_close", buf_close, e_close);
    chk("R4", "hunt_req", hunt_req, e_close);
    chk("R4", "stat_parity_err", stat_parity_err, e_par);
    chk("R5", "irq", irq, e_irq);
    chk("R6", "err_count", err_count, e_cnt);
    chk("R8", "hunting", hunting, e_hunt);
    chk("R10", "stat_crc_err", stat_crc_err, e_crc);
    chk("R12", "in_ready", in_ready, 1);
  endtask

  task automatic do_sync();
    if (mode_extsync) step(0, 0, 0, 0, 1, 0, 0);
    else step(0, 0, 0, 1, 0, 0, 0);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 0; chan_en = 0; mode_even = 0; mode_blkchk = 0; mode_extsync = 0;
    in_valid = 0; in_char = 0; in_crc_bad = 0; carrier_det = 1; sync_found = 0;
    ext_sync = 0; irq_en = 1; cnt_load = 0; cnt_load_val = 0;
    e_cnt = 0; e_hunt = 1; e_par = 0; e_stage = 0; e_crc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R11", "hunting", hunting, 1);
    chk("R11", "err_count", err_count, 0);
    chk("R11", "outputs", {buf_close, hunt_req, irq, stat_parity_err, stat_crc_err}, 0);

    // R12 disabled: chars dropped; R7 load while disabled
    step(1, 8'h00, 1, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 16'hFFFF);
    chk("R7", "load disabled", err_count, 16'hFFFF);
    chan_en = 1;
    step(0, 0, 0, 0, 0, 1, 16'h1234);
    chk("R7", "load ignored enabled", err_count, 16'hFFFF);
    // R8 hunting ignores chars
    step(1, 8'h00, 0, 0, 0, 0, 0);
    chk("R8", "no close while hunting", buf_close, 0);
    do_sync();
    // R1 odd: 8'h00 has zero ones -> error; R6 wrap
    step(1, 8'h00, 0, 0, 0, 0, 0);
    chk("R1", "odd error close", buf_close, 1);
    chk("R6", "wrap", err_count, 16'h0000);
    do_sync();
    step(1, 8'h01, 0, 0, 0, 0, 0);
    chk("R1", "odd good char", buf_close, 0);
    // R2 even
    mode_even = 1;
    step(1, 8'h01, 0, 0, 0, 0, 0);
    chk("R2", "even error", buf_close, 1);
    do_sync();
    step(1, 8'h03, 0, 0, 0, 0, 0);
    chk("R2", "even good", buf_close, 0);
    // R3 check off
    mode_blkchk = 1;
    step(1, 8'h01, 0, 0, 0, 0, 0);
    chk("R3", "no error when off", buf_close, 0);
    mode_blkchk = 0;
    // R5 irq masked
    irq_en = 0;
    step(1, 8'h01, 0, 0, 0, 0, 0);
    chk("R5", "masked irq", irq, 0);
    irq_en = 1;
    // R8 ext mode: sync_found ignored, ext_sync works; R9 carrier ignored
    mode_extsync = 1;
    step(0, 0, 0, 1, 0, 0, 0);
    chk("R8", "sync_found ignored ext", hunting, 1);
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R8", "ext_sync exits", hunting, 0);
    carrier_det = 0;
    step(1, 8'h01, 0, 0, 0, 0, 0);
    chk("R9", "carrier ignored ext", buf_close, 1);
    mode_extsync = 0;
    step(0, 0, 0, 0, 1, 0, 0);
    chk("R8", "ext_sync ignored normal", hunting, 1);
    do_sync();
    step(1, 8'h01, 0, 0, 0, 0, 0);
    chk("R9", "no carrier no accept", buf_close, 0);
    carrier_det = 1;
    // R10 crc lag
    mode_even = 0;
    step(1, 8'h01, 1, 0, 0, 0, 0);
    step(1, 8'h01, 0, 0, 0, 0, 0);
    chk("R10", "lagged crc", stat_crc_err, 1);
    step(1, 8'h01, 0, 0, 0, 0, 0);
    chk("R10", "lagged crc clear", stat_crc_err, 0);

    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 15) == 0) mode_even = $urandom_range(0, 1);
      if ($urandom_range(0, 31) == 0) mode_blkchk = $urandom_range(0, 1);
      if ($urandom_range(0, 31) == 0) mode_extsync = $urandom_range(0, 1);
      if ($urandom_range(0, 31) == 0) chan_en = $urandom_range(0, 3) != 0;
      carrier_det = $urandom_range(0, 7) != 0;
      irq_en = $urandom_range(0, 1);
      step($urandom_range(0, 3) != 0, 8'($urandom), 1'($urandom),
           $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
           $urandom_range(0, 9) == 0, 16'($urandom));
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule